// File: doc/BRIEF.md
# Guarded Single-Precision Magnitude Unit

This execution unit takes one 32-bit IEEE single-precision operand per cycle and returns its magnitude three cycles later. Denormal operands are flushed to zero and reported through a dedicated flag. Quiet NaNs are passed through with their sign intact. Signalling NaNs become the all-ones quiet NaN and raise an invalid flag. Each operation carries a guard word, and only its least significant bit is used. When that bit is clear, the operation produces no result and leaves the status flags alone.

The unit owns a two-bit sticky status register. Updates from this unit, updates that other execution units present in the same cycle, and the current value are OR-merged. A software write port clears or loads the flags. A flags-only variant runs the same classification but returns the flag bits as its result. That variant leaves the status register untouched.

Top module: `fp_abs_unit`

## Requirements
- R1: An operation presented with `in_valid` high and guard bit 0 set produces `out_valid` high exactly 3 clock cycles later. A new operation may be issued in every cycle.
- R2: A non-NaN operand that is not denormal returns with bit 31 cleared and bits 30:0 unchanged. This covers zero and infinity, so 0x80000000 gives 0x00000000 and 0xff7fffff gives 0x7f7fffff. No flag is raised.
- R3: A denormal operand (exponent field 0, fraction non-zero) returns 0x00000000 and raises the flush flag, which is flag bit 1.
- R4: A quiet NaN (exponent field all ones, fraction bit 22 set) returns unchanged, sign included, and raises no flag.
- R5: A signalling NaN (exponent field all ones, fraction bit 22 clear, fraction non-zero) returns 0xffffffff and raises the invalid flag, which is flag bit 0.
- R6: When guard bit 0 is 0, `out_valid` stays low in the result cycle and the sticky flags receive no contribution from the operation. Guard bits 31:1 have no effect.
- R7: The sticky flags change in the same cycle that the result appears. A flag already set stays set until a software write.
- R8: In each cycle, the new flag value also includes `other_flags`, OR-merged bit by bit.
- R9: When `stat_wr_en` is high, `stat_wr_data` replaces the stored flags. Updates from this unit and from `other_flags` that land in the same cycle are ORed on top of the written value.
- R10: With `in_flags_only` high, the result is {30 zero bits, flush, invalid}. The sticky flags are not updated by that operation.
- R11: After reset, `out_valid` is 0 and `sticky_flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe |
| in_operand | input | 32 | Single-precision operand |
| in_guard | input | GUARD_W | Guard word; only bit 0 is used |
| in_flags_only | input | 1 | Select the flags-only variant |
| other_flags | input | 2 | Same-cycle flag updates from other units |
| stat_wr_en | input | 1 | Software write strobe for the status flags |
| stat_wr_data | input | 2 | Value written to the status flags |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Magnitude, or flag word in flags-only mode |
| sticky_flags | output | 2 | Sticky flags: bit 0 invalid, bit 1 flush |

## Verification
Three flag contributions can arrive in one cycle: a retiring guarded operation, an update from another unit, and a software write. Directed cases issue a signalling NaN or a denormal three cycles before a software clear, with `other_flags` driven in that same cycle. The expected outcome is the written value ORed with both updates. A long random run then draws writes, foreign updates and guard values independently. A behavioural model checks the flags and the result in every cycle.

// File: rtl/fp_abs_pkg.sv
package fp_abs_pkg;

    localparam int WORD_W  = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int FLAG_W  = 2;
    localparam int FLG_INVALID = 0;
    localparam int FLG_FLUSH   = 1;
    localparam int QUIET_BIT   = FRAC_W - 1;
    localparam logic [WORD_W-1:0] CANON_QNAN = {WORD_W{1'b1}};

    typedef enum logic [2:0] {
        CLS_ORDINARY,
        CLS_ZERO,
        CLS_SUBNORM,
        CLS_QUIET,
        CLS_SIGNAL
    } opnd_class_e;

    typedef struct packed {
        logic              valid;
        logic              en;
        logic              flags_only;
        opnd_class_e       cls;
        logic [WORD_W-1:0] opnd;
    } issue_t;

    typedef struct packed {
        logic              valid;
        logic              en;
        logic              flags_only;
        logic [FLAG_W-1:0] flags;
        logic [WORD_W-1:0] result;
    } exec_t;

    function automatic opnd_class_e classify(input logic [WORD_W-1:0] w);
        logic [EXP_W-1:0]  e;
        logic [FRAC_W-1:0] f;
        e = w[WORD_W-2 -: EXP_W];
        f = w[FRAC_W-1:0];
        if (e == {EXP_W{1'b1}} && f != '0)
            return f[QUIET_BIT] ? CLS_QUIET : CLS_SIGNAL;
        else if (e == '0)
            return (f == '0) ? CLS_ZERO : CLS_SUBNORM;
        else
            return CLS_ORDINARY;
    endfunction

    function automatic logic [WORD_W-1:0] magnitude(input logic [WORD_W-1:0] w,
                                                    input opnd_class_e cls);
        case (cls)
            CLS_QUIET:   return w;
            CLS_SIGNAL:  return CANON_QNAN;
            CLS_SUBNORM: return '0;
            CLS_ZERO:    return '0;
            default:     return {1'b0, w[WORD_W-2:0]};
        endcase
    endfunction

    function automatic logic [FLAG_W-1:0] raise(input opnd_class_e cls);
        logic [FLAG_W-1:0] r;
        r = '0;
        r[FLG_INVALID] = (cls == CLS_SIGNAL);
        r[FLG_FLUSH]   = (cls == CLS_SUBNORM);
        return r;
    endfunction

endpackage

// File: rtl/fp_abs_issue_stage.sv
module fp_abs_issue_stage
    import fp_abs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_en,
    input  logic              in_flags_only,
    input  logic [WORD_W-1:0] in_opnd,
    output issue_t            s1_q
);
    issue_t s1_d;

    always_comb begin
        s1_d.valid      = in_valid;
        s1_d.en         = in_en;
        s1_d.flags_only = in_flags_only;
        s1_d.cls        = classify(in_opnd);
        s1_d.opnd       = in_opnd;
    end

    always_ff @(posedge clk) begin
        if (rst) s1_q <= '0;
        else     s1_q <= s1_d;
    end

    AST_ISSUE_CARRY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (s1_q.valid && s1_q.en == $past(in_en))); // R1
endmodule

// File: rtl/fp_abs_exec_stage.sv
module fp_abs_exec_stage
    import fp_abs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  issue_t s1_q,
    output exec_t  s2_q
);
    exec_t             s2_d;
    logic [FLAG_W-1:0] fl;
    logic [WORD_W-1:0] mag;

    always_comb begin
        fl  = raise(s1_q.cls);
        mag = magnitude(s1_q.opnd, s1_q.cls);
        s2_d.valid      = s1_q.valid;
        s2_d.en         = s1_q.en;
        s2_d.flags_only = s1_q.flags_only;
        s2_d.flags      = fl;
        s2_d.result     = s1_q.flags_only ? {{(WORD_W-FLAG_W){1'b0}}, fl} : mag;
    end

    always_ff @(posedge clk) begin
        if (rst) s2_q <= '0;
        else     s2_q <= s2_d;
    end

    AST_SIGN_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && !s1_q.flags_only && s1_q.cls != CLS_QUIET && s1_q.cls != CLS_SIGNAL)
        |=> !s2_q.result[WORD_W-1]); // R2
    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && !s1_q.flags_only && s1_q.cls == CLS_SUBNORM)
        |=> (s2_q.result == '0 && s2_q.flags[FLG_FLUSH])); // R3
    AST_SIGNAL_QUIETED: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && !s1_q.flags_only && s1_q.cls == CLS_SIGNAL)
        |=> (s2_q.result == CANON_QNAN && s2_q.flags[FLG_INVALID])); // R5
    AST_FLAGWORD_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && s1_q.flags_only)
        |=> (s2_q.result[WORD_W-1:FLAG_W] == '0)); // R10
endmodule

// File: rtl/fp_abs_status.sv
module fp_abs_status
    import fp_abs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [FLAG_W-1:0] upd_flags,
    input  logic [FLAG_W-1:0] other_flags,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [FLAG_W-1:0] flags_q
);
    logic [FLAG_W-1:0] base;
    logic [FLAG_W-1:0] own;

    always_comb begin
        base = wr_en ? wr_data : flags_q;
        own  = upd_en ? upd_flags : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= base | own | other_flags;
    end

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R7
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !upd_en && other_flags == '0) |=> $stable(flags_q)); // R7
    AST_OTHER_MERGED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & $past(other_flags)) == $past(other_flags))); // R8
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((flags_q & $past(wr_data)) == $past(wr_data))); // R9
endmodule

// File: rtl/fp_abs_unit.sv
module fp_abs_unit
    import fp_abs_pkg::*;
#(
    parameter int GUARD_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_operand,
    input  logic [GUARD_W-1:0] in_guard,
    input  logic               in_flags_only,
    input  logic [FLAG_W-1:0]  other_flags,
    input  logic               stat_wr_en,
    input  logic [FLAG_W-1:0]  stat_wr_data,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_result,
    output logic [FLAG_W-1:0]  sticky_flags
);
    issue_t s1_q;
    exec_t  s2_q;
    logic   retire;
    logic   upd_en;

    fp_abs_issue_stage u_issue (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_en         (in_guard[0]),
        .in_flags_only (in_flags_only),
        .in_opnd       (in_operand),
        .s1_q          (s1_q)
    );

    fp_abs_exec_stage u_exec (
        .clk  (clk),
        .rst  (rst),
        .s1_q (s1_q),
        .s2_q (s2_q)
    );

    always_comb begin
        retire = s2_q.valid && s2_q.en;
        upd_en = retire && !s2_q.flags_only;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= retire;
            if (retire) out_result <= s2_q.result;
        end
    end

    fp_abs_status u_status (
        .clk         (clk),
        .rst         (rst),
        .upd_en      (upd_en),
        .upd_flags   (s2_q.flags),
        .other_flags (other_flags),
        .wr_en       (stat_wr_en),
        .wr_data     (stat_wr_data),
        .flags_q     (sticky_flags)
    );

    AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_guard[0]) |-> ##3 out_valid); // R1
    AST_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_guard[0] && (in_guard[GUARD_W-1:1] != '0)) |-> ##3 !out_valid); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && sticky_flags == '0)); // R11
endmodule

// File: tb/fp_abs_unit_bench.sv
module fp_abs_unit_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic [31:0] in_guard = '0;
    logic        in_flags_only = 1'b0;
    logic [1:0]  other_flags = '0;
    logic        stat_wr_en = 1'b0;
    logic [1:0]  stat_wr_data = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [1:0]  sticky_flags;

    always #(CLK_P/2) clk = ~clk;

    fp_abs_unit u_fp_abs_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
        .in_guard(in_guard), .in_flags_only(in_flags_only), .other_flags(other_flags),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .out_valid(out_valid), .out_result(out_result), .sticky_flags(sticky_flags)
    );

    typedef struct {
        bit          live;
        bit          fo;
        logic [31:0] res;
        logic [1:0]  fl;
        string       tag;
    } slot_t;

    slot_t       p0, p1, pout;
    logic [1:0]  m_flags;
    int          checks = 0;
    int          failures = 0;
    bit          done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic ref_abs(input logic [31:0] x, output logic [31:0] r, output logic [1:0] f);
        int e;
        int m;
        e = int'(x[30:23]);
        m = int'(x[22:0]);
        f = 2'b00;
        if (e == 255 && m != 0) begin
            if (x[22]) r = x;                       // R4
            else begin r = 32'hffffffff; f = 2'b01; end // R5
        end else if (e == 0 && m != 0) begin
            r = 32'h0; f = 2'b10;                   // R3
        end else begin
            r = x & 32'h7fffffff;                   // R2
        end
    endtask

    function automatic string tag_of(input logic [31:0] x, input logic fo);
        if (fo) return "R10";
        if (x[30:23] == 8'hff && x[22:0] != 0) return x[22] ? "R4" : "R5";
        if (x[30:23] == 8'h00 && x[22:0] != 0) return "R3";
        return "R2";
    endfunction

    task automatic compare_outputs(input string ftag);
        check("R1/R6 out_valid", {31'b0, out_valid}, {31'b0, pout.live});
        if (pout.live) check(pout.tag, out_result, pout.res);
        check(ftag, {30'b0, sticky_flags}, {30'b0, m_flags});
    endtask

    task automatic step(input logic v, input logic [31:0] op, input logic [31:0] g,
                        input logic fo, input logic [1:0] oth,
                        input logic wr, input logic [1:0] wd, input string ftag);
        slot_t n;
        logic [31:0] r;
        logic [1:0]  f;
        @(negedge clk);
        compare_outputs(ftag);
        in_valid = v; in_operand = op; in_guard = g; in_flags_only = fo;
        other_flags = oth; stat_wr_en = wr; stat_wr_data = wd;
        @(posedge clk);
        ref_abs(op, r, f);
        n.live = v && g[0];
        n.fo   = fo;
        n.fl   = f;
        n.res  = fo ? {30'b0, f} : r;
        n.tag  = tag_of(op, fo);
        m_flags = (wr ? wd : m_flags) | oth | ((p1.live && !p1.fo) ? p1.fl : 2'b00);
        pout = p1; p1 = p0; p0 = n;
    endtask

    task automatic issue(input logic [31:0] op, input logic [31:0] g, input logic fo, input string ftag);
        step(1'b1, op, g, fo, 2'b00, 1'b0, 2'b00, ftag);
    endtask

    task automatic idle(input int n, input string ftag);
        for (int i = 0; i < n; i++) step(1'b0, 32'h0, 32'h0, 1'b0, 2'b00, 1'b0, 2'b00, ftag);
    endtask

    task automatic clear_model;
        p0 = '{0, 0, 0, 0, ""}; p1 = p0; pout = p0; m_flags = 2'b00;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] op;
        logic [31:0] g;
        clear_model();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check("R11 out_valid", {31'b0, out_valid}, 32'h0);
        check("R11 sticky", {30'b0, sticky_flags}, 32'h0);

        // R1: back-to-back issue, R2 cases
        issue(32'h40400000, 32'h1, 1'b0, "R7");
        issue(32'hbf800000, 32'h1, 1'b0, "R7");
        issue(32'h80000000, 32'h1, 1'b0, "R7");
        issue(32'hff7fffff, 32'h1, 1'b0, "R7");
        issue(32'hff800000, 32'h1, 1'b0, "R7");
        issue(32'h7f800000, 32'h1, 1'b0, "R7");
        // R4 quiet NaN keeps sign, R6 guard off with high bits set
        issue(32'hffffffff, 32'h1, 1'b0, "R7");
        issue(32'hffbfffff, 32'hfffffffe, 1'b0, "R6");
        issue(32'h00400000, 32'h2, 1'b0, "R6");
        idle(4, "R6");
        // R3 denormal then R5 signalling NaN, flags accumulate (R7)
        issue(32'h00400000, 32'h1, 1'b0, "R7");
        issue(32'hffbfffff, 32'h1, 1'b0, "R7");
        idle(4, "R7");
        // R9: software clear
        step(1'b0, 0, 0, 1'b0, 2'b00, 1'b1, 2'b00, "R9");
        idle(2, "R9");
        // R10: flags-only results, sticky untouched
        issue(32'hffbfffff, 32'h1, 1'b1, "R10");
        issue(32'h00000001, 32'h1, 1'b1, "R10");
        issue(32'h3f800000, 32'h1, 1'b1, "R10");
        idle(4, "R10");
        // R8/R9: retire + other unit + software write in one cycle
        issue(32'hffa00000, 32'h1, 1'b0, "R8");
        idle(1, "R8");
        step(1'b0, 0, 0, 1'b0, 2'b10, 1'b1, 2'b00, "R9");
        idle(2, "R9");
        step(1'b0, 0, 0, 1'b0, 2'b00, 1'b1, 2'b00, "R9");
        issue(32'h00000005, 32'h1, 1'b0, "R8");
        idle(1, "R8");
        step(1'b0, 0, 0, 1'b0, 2'b01, 1'b1, 2'b00, "R8");
        idle(3, "R8");

        // random run
        for (int i = 0; i < 3000; i++) begin
            case ($urandom % 6)
                0: op = {$urandom} & 32'h807fffff;
                1: op = ({$urandom} | 32'h7fc00000);
                2: op = ({$urandom} & 32'hffbfffff) | 32'h7f800001;
                3: op = {$urandom} & 32'h80000000;
                default: op = $urandom;
            endcase
            g = $urandom;
            step(($urandom % 4) != 0, op, g, ($urandom % 8) == 0,
                 (($urandom % 8) == 0) ? 2'($urandom) : 2'b00,
                 ($urandom % 16) == 0, 2'($urandom), "R7/R8/R9");
        end
        idle(5, "R7");
        finish_run();
    end
endmodule